// File: doc/BRIEF.md
# Tagged Accelerator Configuration Register Bank

This block is the software-visible register bank placed in front of a loosely coupled accelerator. For each of the accelerator's configuration words it keeps two registers. One is an ordinary data register that is passed straight to the accelerator's configuration port. The other is a hidden companion tag register. The bank also keeps four security words. The source tag is the value every configuration tag and every interleaved input tag must carry. The destination tag is the value to be stamped on output words. The tag gap is the number of data words between two tags in a buffer. The first-tag position is the word index of the first tag in the input buffer. The last three are exported for the load and store paths that handle interleaved tags.

Applications may write and read the data registers. Only a privileged (driver) access may write or read the tag registers and the security words. When software asks for a start, the bank compares every configuration tag against the source tag in a single cycle and checks that the tag gap is not zero. If both checks pass, a one-cycle start pulse goes to the accelerator. If either check fails, the start is swallowed. A sticky violation flag is set instead, and that flag drives an interrupt line. Only a privileged clear removes the flag.

Top module: `tagged_cfg_bank`

## Requirements
- R1: After reset, all data, tag, source-tag, destination-tag and first-position registers are 0 and the tag gap is 1. The start pulse, the interrupt and the read data are 0.
- R2: Word address map with N configuration words: data register i at address i; tag register i at N+i; source tag at 2N; destination tag at 2N+1; tag gap at 2N+2; first-tag position at 2N+3; control at 2N+4. Unmapped addresses ignore writes and read as 0.
- R3: Data registers are written and read at any privilege. Data register i appears on `accCfg` bits [i*W +: W] from the cycle after the write.
- R4: Writes to tag registers and security words take effect only when `busPriv` is 1. A non-privileged read of them returns 0.
- R5: A control write with bit0=1 and bit1=0 is a start request. If all tag registers equal the source tag, the tag gap is non-zero and the violation flag is clear, then `accStart` is 1 for exactly the cycle after the write.
- R6: A start request while any tag register differs from the source tag produces no `accStart`. It sets the violation flag, `abortIrq` goes to 1 and control-register bit0 reads 1.
- R7: A start request while the tag gap is 0 is treated like a tag mismatch: no start, and the violation flag is set.
- R8: The violation flag is sticky and is cleared only by a privileged control write with bit1=1. While the flag is set, start requests produce no `accStart`. A write with bit1=1 never starts the accelerator.
- R9: A read presented on a clock edge returns its value on `busRdData` after that edge. `busRdData` holds its value when no read is presented.
- R10: The source tag, destination tag, tag gap and first-tag position are driven on `srcTag`, `dstTag`, `tagGap` and `firstTagPos`. Privileged reads return the tag registers and the security words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busPriv | input | 1 | Access comes from the privileged driver path |
| busAddr | input | ADDR_W | Word address |
| busWrData | input | WORD_W | Write data |
| busRdData | output | WORD_W | Registered read data |
| accCfg | output | NUM_CFG*WORD_W | Flattened configuration words to the accelerator |
| accStart | output | 1 | One-cycle start pulse to the accelerator |
| abortIrq | output | 1 | Sticky tag-violation interrupt |
| srcTag | output | WORD_W | Expected input tag |
| dstTag | output | WORD_W | Tag stamped on output words |
| tagGap | output | WORD_W | Data words between consecutive tags |
| firstTagPos | output | WORD_W | Word position of the first input tag |

## Verification
The hardest state to reach is a start request that is refused while the tags are already correct, because the violation from an earlier mismatch is still pending. The stimulus first corrupts a single tag and issues a start. It then repairs the tag and issues a second start before clearing, and finally tries a non-privileged clear, which must not release the block. Only after a privileged clear is a successful start expected. The zero-gap refusal is reached the same way, by programming a gap of 0 through the privileged path.

// File: rtl/tbank_pkg.sv
package tbank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_TAG, SEL_SRC, SEL_DST, SEL_GAP, SEL_POS, SEL_CTL
  } sel_e;

  typedef struct packed {
    logic       cfgWe;
    logic       tagWe;
    logic       srcWe;
    logic       dstWe;
    logic       gapWe;
    logic       posWe;
    logic [7:0] wrIdx;
    logic       rdEn;
    sel_e       rdSel;
    logic [7:0] rdIdx;
  } strobe_t;

endpackage

// File: rtl/tbank_ctrl.sv
module tbank_ctrl
  import tbank_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              busPriv,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        ctlBits,
  input  logic              tagsOk,
  input  logic              gapOk,
  output strobe_t           strobe,
  output logic              violation,
  output logic              startPulse
);
  localparam int TAG_BASE = NUM_CFG;
  localparam int SRC_ADDR = 2 * NUM_CFG;
  localparam int DST_ADDR = SRC_ADDR + 1;
  localparam int GAP_ADDR = SRC_ADDR + 2;
  localparam int POS_ADDR = SRC_ADDR + 3;
  localparam int CTL_ADDR = SRC_ADDR + 4;

  sel_e       cls;
  logic [7:0] idx;
  logic       isSecure;
  logic       ctlWr;
  logic       clrReq;
  logic       goReq;

  always_comb begin
    int a;
    a   = int'(busAddr);
    cls = SEL_NONE;
    idx = '0;
    if (a < TAG_BASE) begin
      cls = SEL_CFG;
      idx = 8'(a);
    end else if (a < SRC_ADDR) begin
      cls = SEL_TAG;
      idx = 8'(a - TAG_BASE);
    end else if (a == SRC_ADDR) cls = SEL_SRC;
    else if (a == DST_ADDR) cls = SEL_DST;
    else if (a == GAP_ADDR) cls = SEL_GAP;
    else if (a == POS_ADDR) cls = SEL_POS;
    else if (a == CTL_ADDR) cls = SEL_CTL;
  end

  assign isSecure = (cls == SEL_TAG) || (cls == SEL_SRC) || (cls == SEL_DST) ||
                    (cls == SEL_GAP) || (cls == SEL_POS);

  always_comb begin
    strobe       = '0;
    strobe.wrIdx = idx;
    strobe.rdIdx = idx;
    strobe.cfgWe = busWrEn && (cls == SEL_CFG);
    strobe.tagWe = busWrEn && busPriv && (cls == SEL_TAG);
    strobe.srcWe = busWrEn && busPriv && (cls == SEL_SRC);
    strobe.dstWe = busWrEn && busPriv && (cls == SEL_DST);
    strobe.gapWe = busWrEn && busPriv && (cls == SEL_GAP);
    strobe.posWe = busWrEn && busPriv && (cls == SEL_POS);
    strobe.rdEn  = busRdEn;
    strobe.rdSel = (isSecure && !busPriv) ? SEL_NONE : cls;
  end

  assign ctlWr  = busWrEn && (cls == SEL_CTL);
  assign clrReq = ctlWr && busPriv && ctlBits[1];
  assign goReq  = ctlWr && ctlBits[0] && !ctlBits[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violation  <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      startPulse <= goReq && !violation && tagsOk && gapOk;
      if (clrReq)
        violation <= 1'b0;
      else if (goReq && !violation && !(tagsOk && gapOk))
        violation <= 1'b1;
    end
  end

endmodule

// File: rtl/tbank_dp.sv
module tbank_dp
  import tbank_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int WORD_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobe,
  input  logic [WORD_W-1:0]         wrData,
  input  logic                      violation,
  output logic                      tagsOk,
  output logic                      gapOk,
  output logic [WORD_W-1:0]         rdData,
  output logic [NUM_CFG*WORD_W-1:0] cfgFlat,
  output logic [WORD_W-1:0]         srcTag,
  output logic [WORD_W-1:0]         dstTag,
  output logic [WORD_W-1:0]         tagGap,
  output logic [WORD_W-1:0]         firstTagPos
);
  logic [WORD_W-1:0]  cfgReg [NUM_CFG];
  logic [WORD_W-1:0]  tagReg [NUM_CFG];
  logic [NUM_CFG-1:0] match;
  logic [WORD_W-1:0]  rdNext;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgReg[i] <= '0;
        tagReg[i] <= '0;
      end else begin
        if (strobe.cfgWe && strobe.wrIdx == 8'(i)) cfgReg[i] <= wrData;
        if (strobe.tagWe && strobe.wrIdx == 8'(i)) tagReg[i] <= wrData;
      end
    end
    assign match[i] = (tagReg[i] == srcTag);
    assign cfgFlat[i*WORD_W +: WORD_W] = cfgReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcTag      <= '0;
      dstTag      <= '0;
      tagGap      <= WORD_W'(1);
      firstTagPos <= '0;
    end else begin
      if (strobe.srcWe) srcTag      <= wrData;
      if (strobe.dstWe) dstTag      <= wrData;
      if (strobe.gapWe) tagGap      <= wrData;
      if (strobe.posWe) firstTagPos <= wrData;
    end
  end

  assign tagsOk = &match;
  assign gapOk  = (tagGap != '0);

  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSel)
      SEL_CFG: for (int i = 0; i < NUM_CFG; i++)
                 if (strobe.rdIdx == 8'(i)) rdNext = cfgReg[i];
      SEL_TAG: for (int i = 0; i < NUM_CFG; i++)
                 if (strobe.rdIdx == 8'(i)) rdNext = tagReg[i];
      SEL_SRC: rdNext = srcTag;
      SEL_DST: rdNext = dstTag;
      SEL_GAP: rdNext = tagGap;
      SEL_POS: rdNext = firstTagPos;
      SEL_CTL: rdNext = WORD_W'(violation);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/tagged_cfg_bank.sv
module tagged_cfg_bank
  import tbank_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWrEn,
  input  logic                      busRdEn,
  input  logic                      busPriv,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [WORD_W-1:0]         busWrData,
  output logic [WORD_W-1:0]         busRdData,
  output logic [NUM_CFG*WORD_W-1:0] accCfg,
  output logic                      accStart,
  output logic                      abortIrq,
  output logic [WORD_W-1:0]         srcTag,
  output logic [WORD_W-1:0]         dstTag,
  output logic [WORD_W-1:0]         tagGap,
  output logic [WORD_W-1:0]         firstTagPos
);
  strobe_t strobe;
  logic    tagsOk;
  logic    gapOk;
  logic    violation;

  tbank_ctrl #(.NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busPriv(busPriv), .busAddr(busAddr), .ctlBits(busWrData[1:0]),
    .tagsOk(tagsOk), .gapOk(gapOk), .strobe(strobe),
    .violation(violation), .startPulse(accStart)
  );

  tbank_dp #(.NUM_CFG(NUM_CFG), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .violation(violation), .tagsOk(tagsOk), .gapOk(gapOk),
    .rdData(busRdData), .cfgFlat(accCfg), .srcTag(srcTag),
    .dstTag(dstTag), .tagGap(tagGap), .firstTagPos(firstTagPos)
  );

  assign abortIrq = violation;

endmodule

// File: rtl/tbank_chk.sv
module tbank_chk #(
  parameter int NUM_CFG = 4,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busWrEn,
  input logic                      busPriv,
  input logic [ADDR_W-1:0]         busAddr,
  input logic [WORD_W-1:0]         busWrData,
  input logic [NUM_CFG*WORD_W-1:0] accCfg,
  input logic                      accStart,
  input logic                      abortIrq,
  input logic [WORD_W-1:0]         srcTag,
  input logic [WORD_W-1:0]         dstTag,
  input logic [WORD_W-1:0]         tagGap,
  input logic [WORD_W-1:0]         firstTagPos
);
  localparam int CTL_ADDR = 2 * NUM_CFG + 4;

  logic ctlHit;
  logic clrHit;
  assign ctlHit = busWrEn && (busAddr == ADDR_W'(CTL_ADDR));
  assign clrHit = ctlHit && busPriv && busWrData[1];

  AST_START_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    accStart |-> $past(ctlHit && busWrData[0] && !busWrData[1])); // R5

  AST_START_NEEDS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    accStart |-> $past(tagGap != '0)); // R7

  AST_START_NOT_ON_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    accStart |-> !abortIrq); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (abortIrq && !clrHit) |=> abortIrq); // R8

  AST_NO_START_WHILE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    abortIrq |=> !accStart); // R8

  AST_SECURE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busPriv) |=> ($stable(srcTag) && $stable(dstTag) &&
                               $stable(tagGap) && $stable(firstTagPos))); // R4

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(accCfg)); // R3

endmodule

bind tagged_cfg_bank tbank_chk #(
  .NUM_CFG(NUM_CFG), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busPriv(busPriv),
  .busAddr(busAddr), .busWrData(busWrData), .accCfg(accCfg),
  .accStart(accStart), .abortIrq(abortIrq), .srcTag(srcTag),
  .dstTag(dstTag), .tagGap(tagGap), .firstTagPos(firstTagPos)
);

// File: tb/sim_tagged_cfg_bank.sv
`timescale 1ns/1ps
module sim_tagged_cfg_bank;
  localparam int N  = 4;
  localparam int W  = 32;
  localparam int AW = 8;
  localparam int A_TAG = N;
  localparam int A_SRC = 2 * N;
  localparam int A_DST = 2 * N + 1;
  localparam int A_GAP = 2 * N + 2;
  localparam int A_POS = 2 * N + 3;
  localparam int A_CTL = 2 * N + 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0, busRdEn = 1'b0, busPriv = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [W-1:0]  busWrData = '0;
  logic [W-1:0]  busRdData;
  logic [N*W-1:0] accCfg;
  logic          accStart, abortIrq;
  logic [W-1:0]  srcTag, dstTag, tagGap, firstTagPos;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { logic [W-1:0] v; string r; } exp_t;
  exp_t expQ[$];
  logic rdPend = 1'b0;

  always #4 clk = ~clk;

  tagged_cfg_bank #(.NUM_CFG(N), .WORD_W(W), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busPriv(busPriv), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .accCfg(accCfg), .accStart(accStart),
    .abortIrq(abortIrq), .srcTag(srcTag), .dstTag(dstTag),
    .tagGap(tagGap), .firstTagPos(firstTagPos)
  );

  task automatic chk(input logic ok, input string r, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d, input logic p);
    busAddr = AW'(a); busWrData = d; busPriv = p; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busPriv = 1'b0;
  endtask

  task automatic rd(input int a, input logic p, input logic [W-1:0] e, input string r);
    busAddr = AW'(a); busPriv = p; busRdEn = 1'b1;
    expQ.push_back('{v: e, r: r});
    @(negedge clk);
    busRdEn = 1'b0; busPriv = 1'b0;
  endtask

  // monitor: scoreboard pop one cycle after each read is taken
  always @(posedge clk) rdPend <= busRdEn;
  always @(negedge clk) begin
    if (rdPend) begin
      if (expQ.size() == 0) chk(1'b0, "R9 unexpected read", busRdData, '0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        chk(busRdData == e.v, e.r, busRdData, e.v);
      end
    end
  end

  task automatic startChk(input logic expStart, input logic expIrq, input string r);
    wr(A_CTL, 32'h1, 1'b0);
    chk(accStart == expStart, r, W'(accStart), W'(expStart));
    chk(abortIrq == expIrq, r, W'(abortIrq), W'(expIrq));
    @(negedge clk);
    chk(accStart == 1'b0, {r, " pulse width"}, W'(accStart), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(accStart == 1'b0 && abortIrq == 1'b0, "R1 reset outputs", W'({accStart, abortIrq}), '0);
    chk(accCfg == '0, "R1 reset cfg", accCfg[W-1:0], '0);
    chk(busRdData == '0, "R1 reset rdata", busRdData, '0);
    chk(tagGap == 32'd1 && srcTag == '0, "R1 reset gap", tagGap, 32'd1);
    rd(A_CTL, 1'b0, 32'd0, "R1 control after reset");

    // R3 data registers at user privilege
    for (int i = 0; i < N; i++) wr(i, 32'h1000 + 32'(i) * 32'h11, 1'b0);
    for (int i = 0; i < N; i++)
      chk(accCfg[i*W +: W] == 32'h1000 + 32'(i) * 32'h11, "R3 accCfg slice",
          accCfg[i*W +: W], 32'h1000 + 32'(i) * 32'h11);
    rd(2, 1'b0, 32'h1022, "R3 data readback");
    rd(3, 1'b0, 32'h1033, "R9 back-to-back read");

    // R4 privilege on tags and security words
    wr(A_TAG, 32'h5, 1'b0);
    wr(A_DST, 32'h77, 1'b0);
    chk(dstTag == '0, "R4 user dst write ignored", dstTag, '0);
    rd(A_TAG, 1'b1, 32'h0, "R4 user tag write ignored");
    wr(A_TAG + 1, 32'h9, 1'b1);
    rd(A_TAG + 1, 1'b0, 32'h0, "R4 user tag read hidden");
    rd(A_TAG + 1, 1'b1, 32'h9, "R10 privileged tag read");

    // program security and tags
    wr(A_SRC, 32'hA5A5_0001, 1'b1);
    wr(A_DST, 32'h5A5A_0002, 1'b1);
    wr(A_GAP, 32'd3, 1'b1);
    wr(A_POS, 32'd2, 1'b1);
    for (int i = 0; i < N; i++) wr(A_TAG + i, 32'hA5A5_0001, 1'b1);
    chk(srcTag == 32'hA5A5_0001, "R10 srcTag port", srcTag, 32'hA5A5_0001);
    chk(dstTag == 32'h5A5A_0002, "R10 dstTag port", dstTag, 32'h5A5A_0002);
    chk(tagGap == 32'd3 && firstTagPos == 32'd2, "R10 gap/pos ports", firstTagPos, 32'd2);
    rd(A_GAP, 1'b1, 32'd3, "R10 privileged gap read");
    rd(A_SRC, 1'b0, 32'd0, "R4 user src read hidden");

    // R5 good start
    startChk(1'b1, 1'b0, "R5 start with matching tags");

    // R6 mismatch
    wr(A_TAG + 2, 32'hDEAD, 1'b1);
    startChk(1'b0, 1'b1, "R6 mismatch aborts");
    rd(A_CTL, 1'b0, 32'd1, "R6 violation bit");

    // R8 sticky, start suppressed even after repair
    wr(A_TAG + 2, 32'hA5A5_0001, 1'b1);
    startChk(1'b0, 1'b1, "R8 start blocked while flagged");
    wr(A_CTL, 32'h2, 1'b0);
    chk(abortIrq == 1'b1, "R8 user clear ignored", W'(abortIrq), 32'd1);
    wr(A_CTL, 32'h3, 1'b1);
    chk(abortIrq == 1'b0 && accStart == 1'b0, "R8 clear no start",
        W'({accStart, abortIrq}), '0);
    startChk(1'b1, 1'b0, "R5 start after clear");

    // R7 zero gap
    wr(A_GAP, 32'd0, 1'b1);
    startChk(1'b0, 1'b1, "R7 zero gap aborts");
    wr(A_CTL, 32'h2, 1'b1);
    wr(A_GAP, 32'd1, 1'b1);
    startChk(1'b1, 1'b0, "R7 start with gap 1");

    // R2 unmapped address
    wr(A_CTL + 1, 32'hFFFF_FFFF, 1'b1);
    rd(A_CTL + 1, 1'b1, 32'd0, "R2 unmapped reads zero");
    rd(0, 1'b0, 32'h1000, "R2 data address 0");

    // R9 hold when idle
    @(negedge clk);
    chk(busRdData == 32'h1000, "R9 read data held", busRdData, 32'h1000);
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R9 scoreboard drained", W'(expQ.size()), '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule